// File: doc/BRIEF.md
# Posted-Write Buffer with Bus Hold Handshake

This block sits between a CPU-side write source and a PCI-side master. It holds CPU-to-PCI writes in a small first-in first-out buffer so the CPU can move on before the PCI side has carried them out. Writes enter through a valid/ready port and leave through a second valid/ready port in the order they were accepted. Each write carries an address, a data word and byte enables.

A second agent, such as a southbridge, can ask for the PCI bus by pulling an active-low hold request. The block then stops accepting new writes and lets every buffered write drain to the PCI side. It gives the bus away through an active-low acknowledge only when posting is off and the buffer is empty. This ordering prevents a deadlock between the two buses. When the request goes away, the acknowledge is dropped first. Posting is turned back on one clock later.

Top module: `pwb_hold_bridge`

## Requirements
- R1: After synchronous active-high reset `rst`, `hold_ack_n` is high, `pci_valid` is low and `cpu_ready` is high, so the buffer is empty and posting is enabled.
- R2: Writes leave on `pci_addr`/`pci_data`/`pci_be` in the order they were accepted, with every field intact. A write is accepted on a rising edge where `cpu_valid` and `cpu_ready` are both high. It is removed on a rising edge where `pci_valid` and `pci_ready` are both high.
- R3: When the buffer holds DEPTH writes (default 4), `cpu_ready` is low and no further write is accepted.
- R4: After any rising edge at which `hold_req_n` is sampled low, `cpu_ready` is low.
- R5: Whenever `hold_ack_n` is low, `pci_valid` and `cpu_ready` are both low.
- R6: If `hold_req_n` goes low while the buffer is empty, `hold_ack_n` stays high after the first edge that samples the request. It is low after the second such edge.
- R7: If writes are pending when hold is requested, `hold_ack_n` stays high until they have all drained. It goes low after the edge that follows the edge removing the last write.
- R8: A write presented while the acknowledge is asserted is stalled, not lost. It is accepted once posting resumes and then appears on the PCI side.
- R9: After the first edge that samples `hold_req_n` high while the acknowledge is asserted, `hold_ack_n` is high and `cpu_ready` is still low. After the next edge, `cpu_ready` is high.
- R10: If `hold_req_n` returns high while the buffer is still draining, posting resumes and `hold_ack_n` never goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | CPU offers a write |
| cpu_ready | output | 1 | Block accepts the offered write |
| cpu_addr | input | ADDR_W | Write address |
| cpu_data | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables, active high |
| pci_valid | output | 1 | A buffered write is offered to the PCI side |
| pci_ready | input | 1 | PCI side takes the offered write |
| pci_addr | output | ADDR_W | Address of the oldest write |
| pci_data | output | DATA_W | Data of the oldest write |
| pci_be | output | DATA_W/8 | Byte enables of the oldest write |
| hold_req_n | input | 1 | Bus hold request from the other agent, active low |
| hold_ack_n | output | 1 | Bus hold acknowledge, active low |

## Verification
The hardest state to reach from the ports is a hold request that arrives while writes are still pending. The grant must then wait on the drain, and the drain itself depends on the PCI side. The bench holds `pci_ready` low to keep entries stuck in the buffer, raises the request, and releases the entries one at a time. This shows the acknowledge waiting exactly one edge past the last removal. The same stall technique sets up the case where the request is withdrawn before the buffer empties. It also sets up a write held on the CPU port across a full grant and release.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   // Handshake phases of the bus hold controller
   typedef enum logic [1:0] {
      HS_POST   = 2'd0,  // posting enabled, no hold pending
      HS_DRAIN  = 2'd1,  // posting off, waiting for buffer to empty
      HS_GRANT  = 2'd2,  // acknowledge driven
      HS_RESUME = 2'd3   // acknowledge dropped, posting still off
   } hs_state_t;

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
   parameter int WIDTH = 68,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);
   localparam bit   POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;

   // Pointer advance: natural wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == CMAX);
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !full) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full)  wr_ptr <= wr_nxt;
         if (pop  && !empty) rd_ptr <= rd_nxt;
         case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/pwb_hold_fsm.sv
module pwb_hold_fsm
   import pwb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic hold_req_n,
   input  logic buf_empty,
   output logic post_en,
   output logic ack_n
);

   hs_state_t state, state_nxt;

   always_comb begin
      state_nxt = state;
      unique case (state)
         HS_POST:   if (!hold_req_n) state_nxt = HS_DRAIN;
         HS_DRAIN:  if (hold_req_n)  state_nxt = HS_POST;
                    else if (buf_empty) state_nxt = HS_GRANT;
         HS_GRANT:  if (hold_req_n)  state_nxt = HS_RESUME;
         HS_RESUME: state_nxt = hold_req_n ? HS_POST : HS_DRAIN;
         default:   state_nxt = HS_POST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= HS_POST;
      else     state <= state_nxt;
   end

   assign post_en = (state == HS_POST);
   assign ack_n   = (state != HS_GRANT);

endmodule

// File: rtl/pwb_hold_bridge.sv
module pwb_hold_bridge #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cpu_valid,
   output logic                cpu_ready,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_data,
   input  logic [DATA_W/8-1:0] cpu_be,
   output logic                pci_valid,
   input  logic                pci_ready,
   output logic [ADDR_W-1:0]   pci_addr,
   output logic [DATA_W-1:0]   pci_data,
   output logic [DATA_W/8-1:0] pci_be,
   input  logic                hold_req_n,
   output logic                hold_ack_n
);

   localparam int BE_W  = DATA_W / 8;
   localparam int ENT_W = ADDR_W + DATA_W + BE_W;

   // Elaboration-time parameter checks
   generate
      if (DATA_W % 8 != 0) begin : g_bad_data_w
         $error("pwb_hold_bridge: DATA_W must be a multiple of 8");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("pwb_hold_bridge: DEPTH must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("pwb_hold_bridge: ADDR_W must be positive");
      end
   endgenerate

   logic             post_en;
   logic             buf_empty, buf_full;
   logic             do_push, do_pop;
   logic [ENT_W-1:0] ent_in, ent_out;

   assign cpu_ready = post_en && !buf_full;
   assign do_push   = cpu_valid && cpu_ready;
   assign pci_valid = !buf_empty;
   assign do_pop    = pci_valid && pci_ready;
   assign ent_in    = {cpu_addr, cpu_data, cpu_be};
   assign {pci_addr, pci_data, pci_be} = ent_out;

   pwb_fifo #(
      .WIDTH(ENT_W),
      .DEPTH(DEPTH)
   ) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (do_push),
      .wdata(ent_in),
      .pop  (do_pop),
      .rdata(ent_out),
      .empty(buf_empty),
      .full (buf_full)
   );

   pwb_hold_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .hold_req_n(hold_req_n),
      .buf_empty (buf_empty),
      .post_en   (post_en),
      .ack_n     (hold_ack_n)
   );

endmodule

// File: rtl/pwb_hold_bridge_chk.sv
module pwb_hold_bridge_chk #(
   parameter int DEPTH = 4
) (
   input logic clk,
   input logic rst,
   input logic cpu_valid,
   input logic cpu_ready,
   input logic pci_valid,
   input logic pci_ready,
   input logic hold_req_n,
   input logic hold_ack_n
);

   localparam int OCC_W = $clog2(DEPTH + 1);

   // Port-level occupancy tracker
   logic [OCC_W-1:0] occ;
   logic push_seen, pop_seen;
   assign push_seen = cpu_valid && cpu_ready;
   assign pop_seen  = pci_valid && pci_ready;

   always_ff @(posedge clk) begin
      if (rst) occ <= '0;
      else if (push_seen && !pop_seen) occ <= occ + 1'b1;
      else if (!push_seen && pop_seen) occ <= occ - 1'b1;
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |-> (occ < OCC_W'(DEPTH)));

   a_r2_valid_tracks_occ: assert property (@(posedge clk) disable iff (rst)
      pci_valid == (occ != '0));

   a_r4_hold_stops_posting: assert property (@(posedge clk) disable iff (rst)
      !hold_req_n |=> !cpu_ready);

   a_r5_ack_quiet: assert property (@(posedge clk) disable iff (rst)
      !hold_ack_n |-> (!pci_valid && !cpu_ready));

   a_r6_grant_follows_request: assert property (@(posedge clk) disable iff (rst)
      $fell(hold_ack_n) |-> ($past(!hold_req_n) && $past(!hold_req_n, 2)));

   a_r9_release: assert property (@(posedge clk) disable iff (rst)
      (!hold_ack_n && hold_req_n) |=> (hold_ack_n && !cpu_ready));

endmodule

bind pwb_hold_bridge pwb_hold_bridge_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cpu_valid (cpu_valid),
   .cpu_ready (cpu_ready),
   .pci_valid (pci_valid),
   .pci_ready (pci_ready),
   .hold_req_n(hold_req_n),
   .hold_ack_n(hold_ack_n)
);

// File: tb/pwb_hold_bridge_test.sv
`timescale 1ns/1ps
module pwb_hold_bridge_test;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int BW = DW / 8;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_valid = 1'b0;
   logic          cpu_ready;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_data = '0;
   logic [BW-1:0] cpu_be = '0;
   logic          pci_valid;
   logic          pci_ready = 1'b0;
   logic [AW-1:0] pci_addr;
   logic [DW-1:0] pci_data;
   logic [BW-1:0] pci_be;
   logic          hold_req_n = 1'b1;
   logic          hold_ack_n;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;  // 125 MHz

   pwb_hold_bridge uut (
      .clk(clk), .rst(rst),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
      .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_be(cpu_be),
      .pci_valid(pci_valid), .pci_ready(pci_ready),
      .pci_addr(pci_addr), .pci_data(pci_data), .pci_be(pci_be),
      .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n)
   );

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
         finish_run();
      end
   end

   // Advance one edge; inputs are driven and outputs sampled 1 ns later
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [99:0] act, input logic [99:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
      cpu_valid = 1'b1; cpu_addr = a; cpu_data = d; cpu_be = b;
      while (!cpu_ready) tick();
      tick();
      cpu_valid = 1'b0;
   endtask

   task automatic pop_expect(input string tag, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic [BW-1:0] b);
      while (!pci_valid) tick();
      chk(tag, {pci_addr, pci_data, pci_be}, {a, d, b});
      pci_ready = 1'b1;
      tick();
      pci_ready = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      chk("R1 ack after reset", hold_ack_n, 1'b1);
      chk("R1 pci_valid after reset", pci_valid, 1'b0);
      chk("R1 cpu_ready after reset", cpu_ready, 1'b1);
   endtask

   task automatic t_order();
      push(32'h1000_0000, 32'hAAAA_0001, 4'hF);
      push(32'h1000_0004, 32'h5555_0002, 4'h3);
      push(32'h2000_0008, 32'hDEAD_BEEF, 4'h8);
      pop_expect("R2 first out", 32'h1000_0000, 32'hAAAA_0001, 4'hF);
      pop_expect("R2 second out", 32'h1000_0004, 32'h5555_0002, 4'h3);
      pop_expect("R2 third out", 32'h2000_0008, 32'hDEAD_BEEF, 4'h8);
      chk("R2 empty after drain", pci_valid, 1'b0);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH; i++) push(32'h3000_0000 + 32'(i * 4), 32'(i + 16), 4'(i + 1));
      chk("R3 ready low when full", cpu_ready, 1'b0);
      cpu_valid = 1'b1; cpu_addr = 32'hBAD0_0000; cpu_data = 32'hBAD; cpu_be = 4'h0;
      tick(); tick();
      chk("R3 still not ready", cpu_ready, 1'b0);
      cpu_valid = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         pop_expect("R3 full drain", 32'h3000_0000 + 32'(i * 4), 32'(i + 16), 4'(i + 1));
      chk("R3 extra write not stored", pci_valid, 1'b0);
   endtask

   task automatic t_hold_empty();
      hold_req_n = 1'b0;
      tick();
      chk("R4 posting off after sample", cpu_ready, 1'b0);
      chk("R6 ack not yet after first edge", hold_ack_n, 1'b1);
      tick();
      chk("R6 ack after second edge", hold_ack_n, 1'b0);
      chk("R5 pci idle under ack", pci_valid, 1'b0);
      tick(); tick();
      chk("R5 ack held", hold_ack_n, 1'b0);
      hold_req_n = 1'b1;
      tick();
      chk("R9 ack dropped after release", hold_ack_n, 1'b1);
      chk("R9 posting still off", cpu_ready, 1'b0);
      tick();
      chk("R9 posting resumed", cpu_ready, 1'b1);
   endtask

   task automatic t_hold_pending();
      push(32'h4000_0000, 32'h0000_1111, 4'h1);
      push(32'h4000_0004, 32'h0000_2222, 4'h2);
      hold_req_n = 1'b0;
      for (int i = 0; i < 5; i++) tick();
      chk("R7 no ack while pending", hold_ack_n, 1'b1);
      chk("R4 no posting while draining", cpu_ready, 1'b0);
      pop_expect("R7 drain first", 32'h4000_0000, 32'h0000_1111, 4'h1);
      pop_expect("R7 drain last", 32'h4000_0004, 32'h0000_2222, 4'h2);
      chk("R7 ack not on removal edge", hold_ack_n, 1'b1);
      tick();
      chk("R7 ack one edge after drain", hold_ack_n, 1'b0);
      cpu_valid = 1'b1; cpu_addr = 32'h5000_0000; cpu_data = 32'hCAFE_F00D; cpu_be = 4'hC;
      tick(); tick(); tick();
      chk("R8 write stalled", cpu_ready, 1'b0);
      chk("R8 nothing buffered", pci_valid, 1'b0);
      hold_req_n = 1'b1;
      while (!cpu_ready) tick();
      tick();
      cpu_valid = 1'b0;
      pop_expect("R8 stalled write delivered", 32'h5000_0000, 32'hCAFE_F00D, 4'hC);
   endtask

   task automatic t_abort();
      push(32'h6000_0000, 32'h0000_6666, 4'h6);
      hold_req_n = 1'b0;
      tick(); tick();
      hold_req_n = 1'b1;
      tick();
      chk("R10 posting back", cpu_ready, 1'b1);
      chk("R10 no ack", hold_ack_n, 1'b1);
      tick(); tick();
      chk("R10 still no ack", hold_ack_n, 1'b1);
      pop_expect("R10 entry kept", 32'h6000_0000, 32'h0000_6666, 4'h6);
   endtask

   initial begin
      #1;
      t_reset();
      t_order();
      t_full();
      t_hold_empty();
      t_hold_pending();
      t_abort();
      tick();
      finish_run();
   end

endmodule